// File: doc/BRIEF.md
# Dual-Clock Octet Width Gearbox

This block turns a stream of 4-octet beats arriving on the link clock into a stream of 6-octet beats on a slower, rate-locked device clock. The device clock runs at the link clock times the input width divided by the output width, so for the default widths it runs at two thirds of the link rate. Octets pass through a small dual-clock buffer in units of two octets. The link side publishes its write position to the device side as a Gray-coded count.

Every output beat is a whole number of frames when a frame is 3 or 6 octets. This keeps latency deterministic. The first beat flagged as a start of frame anchors the stream. If a later start-of-frame flag arrives off a 6-octet boundary, the read side throws away the unfinished beat so that the next beat starts on that frame. A per-octet frame-start mask marks where frames begin inside each output beat, based on a frame-size setting.

When the input and output widths are set equal, the buffer is not built. The block becomes a single registered stage, and one clock may drive both clock inputs.

Top module: `octet_gearbox`

## Requirements
- R1: While the resets are held, and after them until the first output beat, `out_valid`, `out_sof` and `out_fstart` are all 0.
- R2: Input octet 0 (bits 7:0) is the earliest octet of its beat, and output byte 0 (bits 7:0) is the earliest octet of its beat. Every accepted octet appears exactly once at the output, in arrival order.
- R3: Input beats before the first beat with `in_sof`=1 are discarded. The first output beat starts with octet 0 of that beat.
- R4: No output beat appears until at least 12 octets (three input beats) have been accepted.
- R5: Input is continuous and the device clock runs at two thirds of the link clock. Once `out_valid` rises, it stays high on every device cycle for as long as the input keeps flowing.
- R6: `out_sof` is 1 exactly on output beats whose byte 0 is octet 0 of an input beat that had `in_sof`=1.
- R7: A beat with `in_sof`=1 may arrive when the octets accepted since the last 6-octet boundary are not a multiple of 6. In that case those 2 or 4 octets are dropped and one device cycle passes with no output. The next beat starts with the flagged octet.
- R8: During a valid beat, bit i of `out_fstart` is 1 when byte i starts a frame. `cfg_frame_octets`=3 gives 6'b001001 and 6 gives 6'b000001. `out_fstart` is 0 whenever `out_valid` is 0.
- R9: Link cycles with `in_valid`=0 write nothing and only delay the stream.
- R10: With equal input and output widths, data, valid and start-of-frame appear on the outputs one device clock after the input, with no buffering.
- R11: The buffer holds 64 octets and never overflows under a continuous stream at the nominal clock ratio, so no octet is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| link_clk | input | 1 | Link-side clock |
| link_rst_n | input | 1 | Link-side asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_sof | input | 1 | Octet 0 of this input beat starts a frame |
| in_data | input | IN_OCTETS*8 | Input octets, octet 0 in bits 7:0 |
| dev_clk | input | 1 | Device-side clock |
| dev_rst_n | input | 1 | Device-side asynchronous reset, active low |
| cfg_frame_octets | input | 4 | Octets per frame (3 or 6), held static while running |
| out_valid | output | 1 | Output beat present |
| out_sof | output | 1 | Byte 0 of this output beat is a flagged frame start |
| out_data | output | OUT_OCTETS*8 | Output octets, earliest in bits 7:0 |
| out_fstart | output | OUT_OCTETS | Per-byte frame-start mask |

## Verification
The hardest case to reach from the ports is realignment. It needs a start-of-frame flag to land part way through the 6-octet window the read side is about to take, at a moment when that window is already fully written. The bench streams aligned three-beat groups, adds one extra beat, and then flags the next beat. This leaves 4 octets stranded just before the flag, and the bench's model removes exactly those octets. The gap-free check depends on the 3:2 clock relation with edges that never coincide, so the bench builds both clocks from fixed half periods.

// File: rtl/gbx_pkg.sv
package gbx_pkg;

   // greatest common divisor, used to size the storage unit in octets
   function automatic int gcd_f(input int a, input int b);
      int x;
      int y;
      int t;
      x = a;
      y = b;
      while (y != 0) begin
         t = x % y;
         x = y;
         y = t;
      end
      return x;
   endfunction

endpackage

// File: rtl/gbx_sync.sv
module gbx_sync #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] meta_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '0;
         q      <= '0;
      end else begin
         meta_q <= d;
         q      <= meta_q;
      end
   end
endmodule

// File: rtl/gbx_chunk_ram.sv
module gbx_chunk_ram #(
   parameter int EW   = 17,
   parameter int AW   = 5,
   parameter int WR_N = 2,
   parameter int RD_N = 3
) (
   input  logic               wr_clk,
   input  logic               wr_en,
   input  logic [AW-1:0]      wr_base,
   input  logic [WR_N*EW-1:0] wr_entries,
   input  logic [AW-1:0]      rd_base,
   output logic [RD_N*EW-1:0] rd_entries
);
   localparam int DEPTH = 1 << AW;

   logic [EW-1:0] mem [DEPTH];

   always_ff @(posedge wr_clk) begin
      if (wr_en) begin
         for (int i = 0; i < WR_N; i++) begin
            mem[wr_base + AW'(i)] <= wr_entries[i*EW +: EW];
         end
      end
   end

   for (genvar j = 0; j < RD_N; j++) begin : g_rd
      assign rd_entries[j*EW +: EW] = mem[rd_base + AW'(j)];
   end
endmodule

// File: rtl/gbx_wr_side.sv
module gbx_wr_side #(
   parameter int IN_CH  = 2,
   parameter int CB     = 16,
   parameter int AW     = 5,
   parameter int WB     = 5,
   parameter int LOG_IN = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic                    in_sof,
   input  logic [IN_CH*CB-1:0]     in_data,
   output logic                    wr_en,
   output logic [AW-1:0]           wr_base,
   output logic [IN_CH*(CB+1)-1:0] wr_entries,
   output logic [WB-1:0]           wgray
);
   localparam int EW = CB + 1;

   logic          aligned_q;
   logic [WB-1:0] wbeat_q;
   logic [WB-1:0] wbeat_nxt;
   logic [WB-1:0] wgray_q;

   assign wr_en     = in_valid && (aligned_q || in_sof);
   assign wbeat_nxt = wbeat_q + 1'b1;
   assign wr_base   = AW'(wbeat_q[WB-2:0]) << LOG_IN;
   assign wgray     = wgray_q;

   for (genvar i = 0; i < IN_CH; i++) begin : g_ent
      if (i == 0) begin : g_first
         assign wr_entries[i*EW +: EW] = {in_sof, in_data[i*CB +: CB]};
      end else begin : g_rest
         assign wr_entries[i*EW +: EW] = {1'b0, in_data[i*CB +: CB]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         aligned_q <= 1'b0;
         wbeat_q   <= '0;
         wgray_q   <= '0;
      end else if (wr_en) begin
         aligned_q <= 1'b1;
         wbeat_q   <= wbeat_nxt;
         wgray_q   <= wbeat_nxt ^ (wbeat_nxt >> 1);
      end
   end

   // R3
   pre_align_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!aligned_q && !(in_valid && in_sof)) |=> $stable(wbeat_q));

   // R2
   gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(wgray_q ^ $past(wgray_q)) <= 1);
endmodule

// File: rtl/gbx_rd_side.sv
module gbx_rd_side #(
   parameter int CB       = 16,
   parameter int AW       = 5,
   parameter int CW       = 6,
   parameter int WB       = 5,
   parameter int LOG_IN   = 1,
   parameter int OUT_CH   = 3,
   parameter int START_CH = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [WB-1:0]            wgray_s,
   input  logic [OUT_CH*(CB+1)-1:0] rd_entries,
   output logic [AW-1:0]            rd_base,
   output logic                     out_valid,
   output logic                     out_sof,
   output logic [OUT_CH*CB-1:0]     out_data
);
   localparam int EW = CB + 1;
   localparam logic [CW-1:0] DEPTH_W = CW'(1 << AW);
   localparam logic [CW-1:0] OUT_W   = CW'(OUT_CH);
   localparam logic [CW-1:0] START_W = CW'(START_CH);

   logic [WB-1:0]        wbin;
   logic [CW-1:0]        wchunks;
   logic [CW-1:0]        rptr_q;
   logic [CW-1:0]        level;
   logic [CW-1:0]        skip_n;
   logic                 skip;
   logic                 can_read;
   logic                 drop;
   logic                 started_q;
   logic [OUT_CH-1:0]    mark;
   logic [OUT_CH*CB-1:0] win_data;

   always_comb begin
      wbin[WB-1] = wgray_s[WB-1];
      for (int i = WB - 2; i >= 0; i--) begin
         wbin[i] = wbin[i+1] ^ wgray_s[i];
      end
   end

   assign wchunks = CW'(wbin) << LOG_IN;
   assign level   = wchunks - rptr_q;
   assign rd_base = rptr_q[AW-1:0];

   for (genvar j = 0; j < OUT_CH; j++) begin : g_win
      assign mark[j]              = rd_entries[j*EW + CB];
      assign win_data[j*CB +: CB] = rd_entries[j*EW +: CB];
   end

   // lowest non-zero offset carrying a frame marker
   always_comb begin
      skip   = 1'b0;
      skip_n = '0;
      for (int j = OUT_CH - 1; j >= 1; j--) begin
         if (mark[j]) begin
            skip   = 1'b1;
            skip_n = CW'(j);
         end
      end
   end

   assign can_read = (started_q || level >= START_W) && level >= OUT_W;
   assign drop     = can_read && skip;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr_q    <= '0;
         started_q <= 1'b0;
         out_valid <= 1'b0;
         out_sof   <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= 1'b0;
         out_sof   <= 1'b0;
         if (level >= START_W) begin
            started_q <= 1'b1;
         end
         if (can_read) begin
            if (skip) begin
               rptr_q <= rptr_q + skip_n;
            end else begin
               rptr_q    <= rptr_q + OUT_W;
               out_valid <= 1'b1;
               out_sof   <= mark[0];
               out_data  <= win_data;
            end
         end
      end
   end

   // R11
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level <= DEPTH_W);

   // R7
   realign_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> !out_valid);

   // R4
   first_beat_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> started_q);
endmodule

// File: rtl/gbx_frame_mask.sv
module gbx_frame_mask #(
   parameter int OCTETS = 6
) (
   input  logic              valid,
   input  logic [3:0]        frame_octets,
   output logic [OCTETS-1:0] mask
);
   logic [3:0] pos;

   always_comb begin
      pos  = '0;
      mask = '0;
      for (int i = 0; i < OCTETS; i++) begin
         mask[i] = valid && (pos == 4'd0);
         if (pos + 4'd1 == frame_octets) pos = '0;
         else                            pos = pos + 4'd1;
      end
   end
endmodule

// File: rtl/octet_gearbox.sv
module octet_gearbox
   import gbx_pkg::*;
#(
   parameter int IN_OCTETS        = 4,
   parameter int OUT_OCTETS       = 6,
   parameter int DEPTH_BEATS_LOG2 = 4
) (
   input  logic                    link_clk,
   input  logic                    link_rst_n,
   input  logic                    in_valid,
   input  logic                    in_sof,
   input  logic [IN_OCTETS*8-1:0]  in_data,
   input  logic                    dev_clk,
   input  logic                    dev_rst_n,
   input  logic [3:0]              cfg_frame_octets,
   output logic                    out_valid,
   output logic                    out_sof,
   output logic [OUT_OCTETS*8-1:0] out_data,
   output logic [OUT_OCTETS-1:0]   out_fstart
);
   localparam int CHUNK_OCT = gcd_f(IN_OCTETS, OUT_OCTETS);
   localparam int CB        = 8 * CHUNK_OCT;
   localparam int EW        = CB + 1;
   localparam int IN_CH     = IN_OCTETS / CHUNK_OCT;
   localparam int OUT_CH    = OUT_OCTETS / CHUNK_OCT;
   localparam int LOG_IN    = $clog2(IN_CH);
   localparam int WB        = DEPTH_BEATS_LOG2 + 1;
   localparam int AW        = DEPTH_BEATS_LOG2 + LOG_IN;
   localparam int CW        = AW + 1;
   localparam int START_CH  = 2 * OUT_CH;

   if (OUT_OCTETS < IN_OCTETS) begin : g_bad_dir
      $error("octet_gearbox: output width must not be below input width");
   end
   if ((1 << LOG_IN) != IN_CH) begin : g_bad_in
      $error("octet_gearbox: input chunks per beat must be a power of two");
   end
   if ((1 << AW) < 2 * START_CH) begin : g_bad_depth
      $error("octet_gearbox: buffer too shallow for the start threshold");
   end

   logic vld_w;

   if (IN_OCTETS == OUT_OCTETS) begin : g_bypass
      always_ff @(posedge dev_clk or negedge dev_rst_n) begin
         if (!dev_rst_n) begin
            vld_w    <= 1'b0;
            out_sof  <= 1'b0;
            out_data <= '0;
         end else begin
            vld_w    <= in_valid;
            out_sof  <= in_valid && in_sof;
            out_data <= in_data;
         end
      end
   end else begin : g_gear
      logic                     wr_en;
      logic [AW-1:0]            wr_base;
      logic [IN_CH*EW-1:0]      wr_entries;
      logic [WB-1:0]            wgray;
      logic [WB-1:0]            wgray_s;
      logic [AW-1:0]            rd_base;
      logic [OUT_CH*EW-1:0]     rd_entries;

      gbx_wr_side #(
         .IN_CH(IN_CH), .CB(CB), .AW(AW), .WB(WB), .LOG_IN(LOG_IN)
      ) wr_i (
         .clk(link_clk), .rst_n(link_rst_n),
         .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
         .wr_en(wr_en), .wr_base(wr_base), .wr_entries(wr_entries),
         .wgray(wgray)
      );

      gbx_chunk_ram #(
         .EW(EW), .AW(AW), .WR_N(IN_CH), .RD_N(OUT_CH)
      ) ram_i (
         .wr_clk(link_clk), .wr_en(wr_en), .wr_base(wr_base),
         .wr_entries(wr_entries), .rd_base(rd_base), .rd_entries(rd_entries)
      );

      gbx_sync #(.W(WB)) sync_i (
         .clk(dev_clk), .rst_n(dev_rst_n), .d(wgray), .q(wgray_s)
      );

      gbx_rd_side #(
         .CB(CB), .AW(AW), .CW(CW), .WB(WB), .LOG_IN(LOG_IN),
         .OUT_CH(OUT_CH), .START_CH(START_CH)
      ) rd_i (
         .clk(dev_clk), .rst_n(dev_rst_n), .wgray_s(wgray_s),
         .rd_entries(rd_entries), .rd_base(rd_base),
         .out_valid(vld_w), .out_sof(out_sof), .out_data(out_data)
      );
   end

   assign out_valid = vld_w;

   gbx_frame_mask #(.OCTETS(OUT_OCTETS)) mask_i (
      .valid(vld_w), .frame_octets(cfg_frame_octets), .mask(out_fstart)
   );
endmodule

// File: tb/octet_gearbox_tb_top.sv
`timescale 1ns/1ps
module octet_gearbox_tb_top;
   logic        lclk = 1'b0;
   logic        dclk = 1'b0;
   logic        lrst_n = 1'b0;
   logic        drst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_sof = 1'b0;
   logic [31:0] in_data = '0;
   logic [3:0]  cfg_f = 4'd3;
   logic        out_valid;
   logic        out_sof;
   logic [47:0] out_data;
   logic [5:0]  out_fstart;

   logic        b_valid = 1'b0;
   logic        b_sof = 1'b0;
   logic [31:0] b_data = '0;
   logic        bo_valid;
   logic        bo_sof;
   logic [31:0] bo_data;
   logic [3:0]  bo_fstart;

   always #2.5  lclk = ~lclk;
   always #3.75 dclk = ~dclk;

   octet_gearbox dut_i (
      .link_clk(lclk), .link_rst_n(lrst_n), .in_valid(in_valid),
      .in_sof(in_sof), .in_data(in_data), .dev_clk(dclk), .dev_rst_n(drst_n),
      .cfg_frame_octets(cfg_f), .out_valid(out_valid), .out_sof(out_sof),
      .out_data(out_data), .out_fstart(out_fstart)
   );

   octet_gearbox #(.IN_OCTETS(4), .OUT_OCTETS(4)) byp_i (
      .link_clk(lclk), .link_rst_n(lrst_n), .in_valid(b_valid),
      .in_sof(b_sof), .in_data(b_data), .dev_clk(lclk), .dev_rst_n(lrst_n),
      .cfg_frame_octets(cfg_f), .out_valid(bo_valid), .out_sof(bo_sof),
      .out_data(bo_data), .out_fstart(bo_fstart)
   );

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // expected octet stream model
   logic [7:0] exp_mem [0:1023];
   bit         exp_sofm [0:1023];
   int exp_wr, exp_rd, pos;
   bit seen_sof;
   logic [7:0] oct;
   int acc_beats;

   // monitor state
   bit mon_en = 1'b0;
   bit streaming = 1'b0;
   int mism, mask_err, gaps, beats_seen, sof_beats, first_b0, acc_at_first;

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, act, expv);
      end
   endtask

   always @(negedge dclk) begin
      if (mon_en) begin
         if (out_valid) begin
            if (first_b0 < 0) begin
               first_b0     = int'(out_data[7:0]);
               acc_at_first = acc_beats;
            end
            beats_seen++;
            for (int i = 0; i < 6; i++) begin
               if (exp_rd + i >= exp_wr) mism++;
               else if (out_data[i*8 +: 8] != exp_mem[exp_rd + i]) mism++;
            end
            if (exp_rd < exp_wr && out_sof != exp_sofm[exp_rd]) mism++;
            if (out_sof) sof_beats++;
            if (out_fstart != ((cfg_f == 4'd3) ? 6'b001001 : 6'b000001)) mask_err++;
            exp_rd += 6;
         end else begin
            if (out_fstart != 6'b0 || out_sof) mask_err++;
            if (first_b0 >= 0 && streaming) gaps++;
         end
      end
   end

   task automatic reset_all();
      mon_en   = 1'b0;
      lrst_n   = 1'b0;
      drst_n   = 1'b0;
      in_valid = 1'b0;
      in_sof   = 1'b0;
      b_valid  = 1'b0;
      b_sof    = 1'b0;
      repeat (5) @(posedge lclk);
      exp_wr = 0; exp_rd = 0; pos = 0; seen_sof = 1'b0; oct = 8'd0;
      acc_beats = 0; mism = 0; mask_err = 0; gaps = 0; beats_seen = 0;
      sof_beats = 0; first_b0 = -1; acc_at_first = 0;
      @(negedge lclk);
      lrst_n = 1'b1;
      drst_n = 1'b1;
      mon_en = 1'b1;
   endtask

   task automatic send_beat(input bit v, input bit sof);
      @(posedge lclk);
      #1;
      in_valid = v;
      in_sof   = v && sof;
      if (v) begin
         in_data = {oct + 8'd3, oct + 8'd2, oct + 8'd1, oct};
         if (sof || seen_sof) begin
            if (sof) begin
               exp_wr = exp_wr - (pos % 6);
               pos = 0;
            end
            seen_sof = 1'b1;
            for (int i = 0; i < 4; i++) begin
               exp_mem[exp_wr]  = oct + 8'(i);
               exp_sofm[exp_wr] = sof && (i == 0);
               exp_wr++;
            end
            pos += 4;
            acc_beats++;
         end
         oct = oct + 8'd4;
      end
   endtask

   task automatic drain();
      send_beat(1'b0, 1'b0);
      streaming = 1'b0;
      repeat (40) @(posedge dclk);
   endtask

   task automatic t_reset();
      mon_en = 1'b0;
      lrst_n = 1'b0;
      drst_n = 1'b0;
      repeat (4) @(posedge dclk);
      @(negedge dclk);
      check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
      check(out_sof == 1'b0 && out_fstart == 6'b0, "R1 sof/fstart in reset",
            int'(out_fstart), 0);
      reset_all();
      repeat (20) @(posedge dclk);
      check(beats_seen == 0, "R1 idle after reset", beats_seen, 0);
   endtask

   task automatic t_basic();
      reset_all();
      cfg_f = 4'd3;
      for (int b = 0; b < 3; b++) send_beat(1'b1, 1'b0);
      streaming = 1'b1;
      for (int b = 0; b < 48; b++) send_beat(1'b1, (b % 3) == 0);
      drain();
      check(mism == 0, "R2 octet order", mism, 0);
      check(first_b0 == 12, "R3 first beat starts at flagged octet", first_b0, 12);
      check(acc_at_first >= 3, "R4 fill before first beat", acc_at_first, 3);
      check(gaps == 0, "R5 no gaps in steady stream", gaps, 0);
      check(sof_beats == 16, "R6 sof beat count", sof_beats, 16);
      check(mask_err == 0, "R8 mask for 3-octet frames", mask_err, 0);
      check(exp_wr - exp_rd == 0, "R11 no octet lost", exp_wr - exp_rd, 0);
      check(beats_seen == 32, "R11 beat count", beats_seen, 32);
   endtask

   task automatic t_frame6();
      reset_all();
      cfg_f = 4'd6;
      for (int b = 0; b < 24; b++) send_beat(1'b1, (b % 3) == 0);
      drain();
      check(mask_err == 0, "R8 mask for 6-octet frames", mask_err, 0);
      check(mism == 0, "R2 order with 6-octet frames", mism, 0);
      check(beats_seen == 16, "R2 beat count 6-octet frames", beats_seen, 16);
      cfg_f = 4'd3;
   endtask

   task automatic t_gaps();
      reset_all();
      for (int b = 0; b < 30; b++) begin
         send_beat(1'b1, (b % 3) == 0);
         send_beat(1'b0, 1'b0);
      end
      drain();
      check(mism == 0, "R9 order with idle cycles", mism, 0);
      check(beats_seen == 20, "R9 no extra writes", beats_seen, 20);
      check(exp_wr - exp_rd == 0, "R9 nothing left behind", exp_wr - exp_rd, 0);
   endtask

   task automatic t_realign();
      reset_all();
      for (int b = 0; b < 9; b++) send_beat(1'b1, (b % 3) == 0);
      send_beat(1'b1, 1'b0);
      for (int b = 0; b < 12; b++) send_beat(1'b1, (b % 3) == 0);
      drain();
      check(mism == 0, "R7 stream after realign", mism, 0);
      check(beats_seen == 14, "R7 partial beat dropped", beats_seen, 14);
      check(sof_beats == 7, "R7 flagged beats after realign", sof_beats, 7);
      check(exp_wr - exp_rd == 0, "R7 nothing stranded", exp_wr - exp_rd, 0);
   endtask

   task automatic t_bypass();
      reset_all();
      cfg_f = 4'd3;
      for (int k = 0; k < 8; k++) begin
         logic [31:0] v;
         bit          s;
         bit          vl;
         v  = 32'h1000_0000 + 32'(k * 32'h0101_0101);
         s  = (k % 3) == 0;
         vl = (k != 5);
         @(posedge lclk);
         #1;
         b_valid = vl;
         b_sof   = s;
         b_data  = v;
         @(posedge lclk);
         @(negedge lclk);
         check(bo_valid == vl, "R10 bypass valid", int'(bo_valid), int'(vl));
         if (vl) begin
            check(bo_data == v, "R10 bypass data", int'(bo_data), int'(v));
            check(bo_sof == s, "R10 bypass sof", int'(bo_sof), int'(s));
            check(bo_fstart == 4'b1001, "R8 bypass mask", int'(bo_fstart), 9);
         end
      end
      b_valid = 1'b0;
   endtask

   initial begin
      #600us;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got %0d expected %0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_basic();
      t_frame6();
      t_gaps();
      t_realign();
      t_bypass();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule